// File: doc/BRIEF.md
# Sleep Control Register with Request Decode

This block holds one 16-bit power-management control word on a simple register bus and turns software sleep commands into hardware request pulses. A write that reaches the block's offset loads the word. If the written value has its sleep-trigger bit set, the block reads a 3-bit sleep-type field from the same value. It then issues a single-cycle request for power-off, for suspend-to-RAM, or for suspend-to-disk. The trigger bit itself is never kept in storage, so a read never shows it.

The suspend-to-disk code comes from an input and can be chosen freely. It is compared against the type field only when the type is neither 0 nor 1. A match gives a disk pulse, and a power-off pulse follows in the next cycle. Two side inputs from the power-management logic can force the interrupt-enable bit of the stored word on or off, whatever the bus is doing. The power sequencer downstream acts on the request pulses.

Top module: `pm_sleep_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the stored word reads 0 and all three request outputs are low.
- R2: A write (bus_sel and bus_wr high) with bus_addr equal to 4 stores bus_wdata with bit 13 forced to 0. A read (bus_sel high, bus_wr low) at address 4 returns the stored word at once. Any other bus state returns 0 on bus_rdata.
- R3: A write to any address other than 4 leaves the stored word unchanged and raises no request.
- R4: A write to address 4 with bit 13 set and bits 12:10 equal to 0 raises req_shutdown for exactly the one cycle after the write edge.
- R5: A write to address 4 with bit 13 set and bits 12:10 equal to 1 raises req_suspend_ram for exactly the one cycle after the write edge.
- R6: A write to address 4 with bit 13 set and a type of 2 or more that equals disk_sleep_code raises req_suspend_disk in the cycle after the write edge, and raises req_shutdown in the cycle after that.
- R7: A write to address 4 with bit 13 clear, or with a type of 2 or more that differs from disk_sleep_code, raises no request.
- R8: A type of 0 or 1 never raises req_suspend_disk, even when disk_sleep_code equals the type.
- R9: irq_en_set drives stored bit 0 to 1 at the next edge. irq_en_clr drives it to 0 only when irq_en_set is low. Either input overrides bit 0 of a write in the same cycle. Without them, bit 0 follows the written data.
- R10: When a delayed power-off from a disk request lands in the same cycle as a new request pulse, both outputs are high in that cycle. Two power-off causes merge into one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| disk_sleep_code | input | 3 | Type code that means suspend-to-disk |
| irq_en_set | input | 1 | Forces the interrupt-enable bit to 1 |
| irq_en_clr | input | 1 | Forces the interrupt-enable bit to 0 when irq_en_set is low |
| req_shutdown | output | 1 | One-cycle power-off request |
| req_suspend_ram | output | 1 | One-cycle suspend-to-RAM request |
| req_suspend_disk | output | 1 | One-cycle suspend-to-disk request |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a bus write and a forcing side input, which both act on bit 0 of the stored word. The bench drives every mix of write data bit 0, irq_en_set and irq_en_clr in the same cycle and compares the readback with the priority of R9. The second pair is the delayed power-off of a disk request and a new request from a back-to-back write. The bench issues a disk write followed directly by a type-0 or type-1 write, and checks that the outputs overlap in exactly the predicted cycle and fall in the next one.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;

  parameter int unsigned CTL_W      = 16;
  parameter int unsigned TYPE_W     = 3;
  parameter int unsigned TYPE_LSB   = 10;
  parameter int unsigned TRIG_BIT   = 13;
  parameter int unsigned IRQEN_BIT  = 0;

  localparam logic [CTL_W-1:0] TRIG_MASK = CTL_W'(1) << TRIG_BIT;

  localparam logic [TYPE_W-1:0] TYPE_OFF = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] TYPE_RAM = TYPE_W'(1);

  typedef struct packed {
    logic off;
    logic ram;
    logic disk;
  } sleep_req_t;

  function automatic logic [TYPE_W-1:0] type_field(input logic [CTL_W-1:0] v);
    return v[TYPE_LSB +: TYPE_W];
  endfunction

  function automatic sleep_req_t sleep_decode(input logic             trig,
                                              input logic [TYPE_W-1:0] typ,
                                              input logic [TYPE_W-1:0] disk_code);
    sleep_req_t r;
    r = '0;
    if (trig) begin
      if (typ == TYPE_OFF)      r.off  = 1'b1;
      else if (typ == TYPE_RAM) r.ram  = 1'b1;
      else if (typ == disk_code) r.disk = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [CTL_W-1:0] store_value(input logic [CTL_W-1:0] old_v,
                                                   input logic             wr,
                                                   input logic [CTL_W-1:0] wdata,
                                                   input logic             force_on,
                                                   input logic             force_off);
    logic [CTL_W-1:0] v;
    v = wr ? (wdata & ~TRIG_MASK) : old_v;
    if (force_on)       v[IRQEN_BIT] = 1'b1;
    else if (force_off) v[IRQEN_BIT] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/pm_ctl_store.sv
module pm_ctl_store
  import pm_sleep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CTL_W-1:0] wdata,
  input  logic             force_on,
  input  logic             force_off,
  output logic [CTL_W-1:0] ctl_q
);

  logic [CTL_W-1:0] ctl_d;

  always_comb begin
    ctl_d = store_value(ctl_q, wr_hit, wdata, force_on, force_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

endmodule

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_sleep_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [CTL_W-1:0]  wdata,
  input  logic [TYPE_W-1:0] disk_code,
  output logic              slp_hit,
  output logic              off_q,
  output logic              ram_q,
  output logic              disk_q
);

  sleep_req_t req_now;

  assign slp_hit = wr_hit & wdata[TRIG_BIT];

  always_comb begin
    req_now = sleep_decode(slp_hit, type_field(wdata), disk_code);
  end

  // disk_q doubles as the pending flag for the trailing power-off pulse
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= 1'b0;
      ram_q  <= 1'b0;
      disk_q <= 1'b0;
    end else begin
      off_q  <= req_now.off | disk_q;
      ram_q  <= req_now.ram;
      disk_q <= req_now.disk;
    end
  end

endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_sleep_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned REG_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic [TYPE_W-1:0] disk_sleep_code,
  input  logic              irq_en_set,
  input  logic              irq_en_clr,
  output logic              req_shutdown,
  output logic              req_suspend_ram,
  output logic              req_suspend_disk
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

  logic             addr_hit;
  logic             wr_hit;
  logic             rd_hit;
  logic             slp_hit;
  logic [CTL_W-1:0] ctl_q;

  assign addr_hit = bus_sel && (bus_addr == OFS);
  assign wr_hit   = addr_hit && bus_wr;
  assign rd_hit   = addr_hit && !bus_wr;

  pm_ctl_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata),
    .force_on  (irq_en_set),
    .force_off (irq_en_clr),
    .ctl_q     (ctl_q)
  );

  pm_sleep_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata),
    .disk_code (disk_sleep_code),
    .slp_hit   (slp_hit),
    .off_q     (req_shutdown),
    .ram_q     (req_suspend_ram),
    .disk_q    (req_suspend_disk)
  );

  assign bus_rdata = rd_hit ? ctl_q : '0;

endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk
  import pm_sleep_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_hit,
  input logic              slp_hit,
  input logic [CTL_W-1:0]  bus_wdata,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [TYPE_W-1:0] disk_sleep_code,
  input logic              irq_en_set,
  input logic              irq_en_clr,
  input logic              req_shutdown,
  input logic              req_suspend_ram,
  input logic              req_suspend_disk
);

  assert_trig_not_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> !ctl_q[TRIG_BIT]);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !irq_en_set && !irq_en_clr) |=> $stable(ctl_q));

  assert_ram_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slp_hit && bus_wdata[TYPE_LSB +: TYPE_W] == TYPE_RAM) |=> req_suspend_ram);

  assert_disk_then_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend_disk |=> req_shutdown);

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_hit |=> (!req_suspend_ram && !req_suspend_disk));

  assert_disk_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_suspend_disk && req_suspend_ram));

  assert_force_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_set |=> ctl_q[IRQEN_BIT]);

  assert_force_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_clr && !irq_en_set) |=> !ctl_q[IRQEN_BIT]);

endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_hit           (wr_hit),
  .slp_hit          (slp_hit),
  .bus_wdata        (bus_wdata),
  .ctl_q            (ctl_q),
  .disk_sleep_code  (disk_sleep_code),
  .irq_en_set       (irq_en_set),
  .irq_en_clr       (irq_en_clr),
  .req_shutdown     (req_shutdown),
  .req_suspend_ram  (req_suspend_ram),
  .req_suspend_disk (req_suspend_disk)
);

// File: tb/pm_sleep_ctl_tb.sv
module pm_sleep_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic [2:0]  disk_sleep_code = 3'd0;
  logic        irq_en_set = 1'b0;
  logic        irq_en_clr = 1'b0;
  logic        req_shutdown, req_suspend_ram, req_suspend_disk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pm_sleep_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .disk_sleep_code(disk_sleep_code), .irq_en_set(irq_en_set),
    .irq_en_clr(irq_en_clr), .req_shutdown(req_shutdown),
    .req_suspend_ram(req_suspend_ram), .req_suspend_disk(req_suspend_disk)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_req(input string tag, input logic o, input logic r, input logic d);
    chk(tag, {13'd0, req_shutdown, req_suspend_ram, req_suspend_disk}, {13'd0, o, r, d});
  endtask

  // called just after a negedge; returns just after the next negedge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [15:0] rd(input logic [3:0] a);
    return 16'd0;
  endfunction

  task automatic rdchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] shadow;
    repeat (3) @(negedge clk);
    chk_req("R1 reset outputs", 1'b0, 1'b0, 1'b0);
    rdchk("R1 reset value", 4'd4, 16'h0000);
    rst_n = 1'b1;
    idle();
    rdchk("R1 after release", 4'd4, 16'h0000);
    chk_req("R1 idle outputs", 1'b0, 1'b0, 1'b0);

    // R2 storage, trigger bit dropped, readback gating
    foreach (shadow[i]) begin end
    for (int k = 0; k < 16; k++) begin
      logic [15:0] d;
      d = 16'h1 << k;
      d = d ^ 16'h5a5a ^ (16'h0101 * k[7:0]);
      d[13] = 1'b0;
      wr(4'd4, d);
      rdchk("R2 readback", 4'd4, d);
    end
    wr(4'd4, 16'hC3A5 & ~16'h1C00 | 16'h2000 | (16'd5 << 10)); // type 5 trigger
    disk_sleep_code = 3'd0;
    shadow = (16'hC3A5 & ~16'h1C00 | (16'd5 << 10));
    shadow[13] = 1'b0;
    rdchk("R2 trigger bit cleared", 4'd4, shadow);
    rdchk("R2 other offset reads 0", 4'd6, 16'h0000);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd4; #1;
    chk("R2 write cycle reads 0", bus_rdata, 16'h0000);
    bus_sel = 1'b0; bus_wr = 1'b0;

    // R3 other addresses ignored, even with trigger set
    for (int a = 0; a < 16; a++) begin
      if (a == 4) continue;
      wr(4'(a), 16'h2000 | 16'h0FF0);
      chk_req("R3 no request", 1'b0, 1'b0, 1'b0);
      idle();
      chk_req("R3 no late request", 1'b0, 1'b0, 1'b0);
      rdchk("R3 value kept", 4'd4, shadow);
    end

    // R4..R8 sweep of type x disk code, trigger set and clear
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 8; t++) begin
        for (int s = 0; s < 2; s++) begin
          logic eo, er, ed;
          logic [15:0] d;
          disk_sleep_code = 3'(c);
          d = 16'h0042 | (16'(t) << 10) | (s == 1 ? 16'h2000 : 16'h0000);
          eo = (s == 1) && (t == 0);
          er = (s == 1) && (t == 1);
          ed = (s == 1) && (t >= 2) && (t == c);
          wr(4'd4, d);
          if (t == 0)      chk_req("R4 shutdown pulse", eo, er, ed);
          else if (t == 1) chk_req("R5 ram pulse / R8 no disk", eo, er, ed);
          else if (ed)     chk_req("R6 disk pulse", eo, er, ed);
          else             chk_req("R7 no request", eo, er, ed);
          idle();
          chk_req(ed ? "R6 trailing shutdown" : "R4 R5 single cycle", ed, 1'b0, 1'b0);
          idle();
          chk_req("R6 trailing single cycle", 1'b0, 1'b0, 1'b0);
          rdchk("R2 stored after sleep write", 4'd4, d & 16'hDFFF);
        end
      end
    end

    // R9 force inputs vs same-cycle write of bit 0
    for (int m = 0; m < 16; m++) begin
      logic wflag, b0, fs, fc, exp0;
      logic [15:0] d;
      wflag = m[3]; b0 = m[2]; fs = m[1]; fc = m[0];
      wr(4'd4, 16'h0100 | {15'd0, ~b0});
      d = 16'h0100 | {15'd0, ~b0};
      irq_en_set = fs; irq_en_clr = fc;
      if (wflag) begin
        wr(4'd4, 16'h0300 | {15'd0, b0});
        d = 16'h0300 | {15'd0, b0};
      end else idle();
      irq_en_set = 1'b0; irq_en_clr = 1'b0;
      exp0 = fs ? 1'b1 : (fc ? 1'b0 : d[0]);
      d[0] = exp0;
      rdchk("R9 force priority", 4'd4, d);
    end

    // R10 coincidence of trailing shutdown with a fresh request
    disk_sleep_code = 3'd6;
    wr(4'd4, 16'h2000 | (16'd6 << 10));
    chk_req("R10 disk first", 1'b0, 1'b0, 1'b1);
    wr(4'd4, 16'h2000);
    chk_req("R10 merged shutdown", 1'b1, 1'b0, 1'b0);
    idle();
    chk_req("R10 merged falls", 1'b0, 1'b0, 1'b0);
    wr(4'd4, 16'h2000 | (16'd6 << 10));
    wr(4'd4, 16'h2000 | (16'd1 << 10));
    chk_req("R10 ram with trailing shutdown", 1'b1, 1'b1, 1'b0);
    idle();
    chk_req("R10 overlap falls", 1'b0, 1'b0, 1'b0);
    wr(4'd4, 16'h2000 | (16'd6 << 10));
    wr(4'd4, 16'h2000 | (16'd6 << 10));
    chk_req("R10 second disk with shutdown", 1'b1, 1'b0, 1'b1);
    idle();
    chk_req("R10 last trailing shutdown", 1'b1, 1'b0, 1'b0);
    idle();
    chk_req("R10 all quiet", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule